// File: doc/BRIEF.md
# Level Trigger with Hysteresis

This block watches a stream of signed two's-complement sample codes. It raises a one-cycle trigger pulse when the signal passes a programmed level in the chosen direction. Each pulse comes with the running index of the sample that made the crossing. The level is given directly as a code. A full-scale code of 2^15 stands for half the analog span, so any conversion from volts is done outside the block.

Once the block fires, it disarms. It will not fire again until a sample reaches a second threshold, the re-arm level, which sits on the far side of the trigger level. Noise that dithers around the trigger level therefore produces one pulse rather than a burst. The threshold values and the edge choice are captured only while the block is disabled. Enabling the block starts a run in the armed state, with the sample index counting from zero.

Top module: `hyst_level_trigger`

## Requirements
- R1: After reset, `trigPulse` is 0 and `trigIndex` is 0.
- R2: With `fallingEdge` = 0, a valid sample fires when the previous valid sample is strictly below `trigLevel` and the current one is at or above it. A one-code step onto the level is enough to fire. All codes are compared as signed two's-complement values.
- R3: With `fallingEdge` = 1, a valid sample fires when the previous valid sample is strictly above `trigLevel` and the current one is at or below it. An upward crossing does not fire in this mode.
- R4: `trigPulse` is high for exactly one cycle. That cycle directly follows the clock edge at which the crossing sample was accepted.
- R5: `trigIndex` gives the position of the firing sample among the valid samples accepted since enable, counting the first as 0. It holds that value until the next pulse.
- R6: After a pulse, no further pulse occurs until a valid sample meets the re-arm condition. For a rising edge that condition is at or below `rearmLevel`; for a falling edge it is at or above `rearmLevel`.
- R7: The next valid sample after re-arming can fire again if it crosses.
- R8: The first valid sample after enable never fires, since it has no predecessor.
- R9: Cycles with `sampleValid` low have no effect. They do not advance the index and do not become the previous sample.
- R10: While `enable` is low, `trigPulse` is 0, `trigIndex` is 0 and the block is disarmed. A new run starts armed.
- R11: Changes to `trigLevel`, `rearmLevel` and `fallingEdge` while enabled have no effect. The values present while disabled are the ones used by the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low clears state and loads configuration |
| sampleValid | input | 1 | Qualifies `sampleCode` this cycle |
| sampleCode | input | DATA_W | Signed sample code |
| trigLevel | input | DATA_W | Signed trigger level code |
| rearmLevel | input | DATA_W | Signed re-arm level code |
| fallingEdge | input | 1 | 0 = rising edge, 1 = falling edge |
| trigPulse | output | 1 | One-cycle trigger pulse |
| trigIndex | output | IDX_W | Index of the sample that fired |

## Verification
The bench steps onto the level by one code and lands exactly on it. A design that used a strict comparison would miss those hits. It also crosses zero from -1 upward, which an unsigned compare would not see as a crossing. The bench then dithers above the level without touching the re-arm threshold; a block with no hysteresis would fire repeatedly there. Further cases change the thresholds mid-run, insert invalid cycles carrying out-of-range codes, and fire immediately after re-enable. These expose a design that tracks live configuration, counts or stores qualified-off samples, or fails to restart armed.

// File: rtl/hyst_trig_pkg.sv
`timescale 1ns/1ps
package hyst_trig_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic clear;    // drop run state (previous sample, index, outputs)
    logic loadCfg;  // capture configuration inputs into shadow registers
    logic step;     // accept the current sample
    logic fire;     // current sample produces a trigger
  } trig_strb_t;
endpackage

// File: rtl/hyst_trig_dp.sv
`timescale 1ns/1ps
module hyst_trig_dp
  import hyst_trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  trig_strb_t               strb,
  input  logic signed [DATA_W-1:0] sampleCode,
  input  logic signed [DATA_W-1:0] trigLevel,
  input  logic signed [DATA_W-1:0] rearmLevel,
  input  logic                     fallingEdge,
  output logic                     crossHit,
  output logic                     rearmHit,
  output logic                     trigPulse,
  output logic [IDX_W-1:0]         trigIndex
);
  logic signed [DATA_W-1:0] cfgLevel, cfgRearm, prevCode;
  logic                     cfgFall, havePrev;
  logic [IDX_W-1:0]         sampleIdx;

  // Shadow configuration, written only while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLevel <= '0;
      cfgRearm <= '0;
      cfgFall  <= 1'b0;
    end else if (strb.loadCfg) begin
      cfgLevel <= trigLevel;
      cfgRearm <= rearmLevel;
      cfgFall  <= fallingEdge;
    end
  end

  // Previous accepted sample and running sample index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode  <= '0;
      havePrev  <= 1'b0;
      sampleIdx <= '0;
    end else if (strb.clear) begin
      havePrev  <= 1'b0;
      sampleIdx <= '0;
    end else if (strb.step) begin
      prevCode  <= sampleCode;
      havePrev  <= 1'b1;
      sampleIdx <= sampleIdx + 1'b1;
    end
  end

  // Comparators
  logic prevBelow, prevAbove, curAtOrAbove, curAtOrBelow;
  logic curLeRearm, curGeRearm;
  always_comb begin
    prevBelow    = prevCode < cfgLevel;
    prevAbove    = prevCode > cfgLevel;
    curAtOrAbove = sampleCode >= cfgLevel;
    curAtOrBelow = sampleCode <= cfgLevel;
    curLeRearm   = sampleCode <= cfgRearm;
    curGeRearm   = sampleCode >= cfgRearm;
    if (cfgFall) begin
      crossHit = havePrev && prevAbove && curAtOrBelow;
      rearmHit = curGeRearm;
    end else begin
      crossHit = havePrev && prevBelow && curAtOrAbove;
      rearmHit = curLeRearm;
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      trigIndex <= '0;
    end else if (strb.clear) begin
      trigPulse <= 1'b0;
      trigIndex <= '0;
    end else begin
      trigPulse <= strb.fire;
      if (strb.fire) trigIndex <= sampleIdx;
    end
  end
endmodule

// File: rtl/hyst_trig_ctrl.sv
`timescale 1ns/1ps
module hyst_trig_ctrl
  import hyst_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sampleValid,
  input  logic       crossHit,
  input  logic       rearmHit,
  output trig_strb_t strb
);
  logic enD, armed;

  always_comb begin
    strb.clear   = !enable;
    strb.loadCfg = !enable;
    strb.step    = enable && sampleValid;
    strb.fire    = enable && sampleValid && armed && crossHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enD   <= 1'b0;
      armed <= 1'b0;
    end else begin
      enD <= enable;
      if (!enable)                              armed <= 1'b0;
      else if (!enD)                            armed <= 1'b1;
      else if (strb.fire)                       armed <= 1'b0;
      else if (strb.step && !armed && rearmHit) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/hyst_level_trigger.sv
`timescale 1ns/1ps
module hyst_level_trigger
  import hyst_trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleCode,
  input  logic [DATA_W-1:0] trigLevel,
  input  logic [DATA_W-1:0] rearmLevel,
  input  logic              fallingEdge,
  output logic              trigPulse,
  output logic [IDX_W-1:0]  trigIndex
);
  trig_strb_t strb;
  logic       crossHit, rearmHit;

  hyst_trig_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sampleValid (sampleValid),
    .crossHit    (crossHit),
    .rearmHit    (rearmHit),
    .strb        (strb)
  );

  hyst_trig_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleCode  ($signed(sampleCode)),
    .trigLevel   ($signed(trigLevel)),
    .rearmLevel  ($signed(rearmLevel)),
    .fallingEdge (fallingEdge),
    .crossHit    (crossHit),
    .rearmHit    (rearmHit),
    .trigPulse   (trigPulse),
    .trigIndex   (trigIndex)
  );
endmodule

// File: rtl/hyst_trig_chk.sv
`timescale 1ns/1ps
module hyst_trig_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sampleValid,
  input logic             trigPulse,
  input logic [IDX_W-1:0] trigIndex
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!trigPulse && trigIndex == '0));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R8
  pulse_from_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(enable && sampleValid));

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!trigPulse && trigIndex == '0));

  // R5
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !trigPulse) |-> $stable(trigIndex));
endmodule

bind hyst_level_trigger hyst_trig_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sampleValid (sampleValid),
  .trigPulse   (trigPulse),
  .trigIndex   (trigIndex)
);

// File: tb/test_hyst_level_trigger.sv
`timescale 1ns/1ps
module test_hyst_level_trigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleCode = '0;
  logic [15:0] trigLevel = '0;
  logic [15:0] rearmLevel = '0;
  logic        fallingEdge = 1'b0;
  logic        trigPulse;
  logic [15:0] trigIndex;

  int nVec = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  hyst_level_trigger i_hyst_level_trigger (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .sampleCode(sampleCode), .trigLevel(trigLevel), .rearmLevel(rearmLevel),
    .fallingEdge(fallingEdge), .trigPulse(trigPulse), .trigIndex(trigIndex)
  );

  task automatic check(input logic expPulse, input int expIdx, input string req);
    nVec++;
    if (trigPulse !== expPulse || trigIndex !== 16'(expIdx)) begin
      nBad++;
      $display("FAIL %s: pulse=%0b index=%0d expected pulse=%0b index=%0d",
               req, trigPulse, trigIndex, expPulse, expIdx);
    end
  endtask

  // Present one valid sample, then check the registered outputs
  task automatic push(input int code, input logic expPulse, input int expIdx,
                      input string req);
    sampleValid = 1'b1;
    sampleCode  = 16'(code);
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    check(expPulse, expIdx, req);
  endtask

  // Invalid cycle carrying a code that would matter if it were used
  task automatic idle(input int code, input int expIdx, input string req);
    sampleValid = 1'b0;
    sampleCode  = 16'(code);
    @(posedge clk);
    @(negedge clk);
    check(1'b0, expIdx, req);
  endtask

  task automatic startRun(input int lvl, input int rearm, input logic fall);
    @(negedge clk);
    enable      = 1'b0;
    trigLevel   = 16'(lvl);
    rearmLevel  = 16'(rearm);
    fallingEdge = fall;
    @(negedge clk);
    check(1'b0, 0, "R10 disabled");
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(1'b0, 0, "R1 reset");
  endtask

  task automatic testRising();
    startRun(100, 50, 1'b0);
    push(90,  1'b0, 0, "R8 first sample");
    push(99,  1'b0, 0, "R2 below");
    push(100, 1'b1, 2, "R2 step onto level");
    push(101, 1'b0, 2, "R4 single pulse");
    push(99,  1'b0, 2, "R6 no rearm");
    push(100, 1'b0, 2, "R6 recross disarmed");
    push(50,  1'b0, 2, "R6 rearm sample");
    push(120, 1'b1, 7, "R7 fire after rearm");
    idle(0, 7, "R5 index held");
  endtask

  task automatic testFalling();
    startRun(-100, -50, 1'b1);
    push(0,    1'b0, 0, "R8 first");
    push(-100, 1'b1, 1, "R3 fall onto level");
    push(-200, 1'b0, 1, "R4 single pulse");
    push(-60,  1'b0, 1, "R3 upward no fire");
    push(-150, 1'b0, 1, "R6 no rearm");
    push(-50,  1'b0, 1, "R6 rearm");
    push(-101, 1'b1, 6, "R7 fire after rearm");
  endtask

  task automatic testFirstAbove();
    startRun(100, 50, 1'b0);
    push(200, 1'b0, 0, "R8 first above level");
    push(300, 1'b0, 0, "R2 no crossing");
  endtask

  task automatic testInvalid();
    startRun(100, 50, 1'b0);
    push(90, 1'b0, 0, "R9 start");
    idle(200, 0, "R9 invalid high code");
    idle(200, 0, "R9 invalid again");
    push(95, 1'b0, 0, "R9 below");
    push(100, 1'b1, 2, "R9 invalid not counted");
  endtask

  task automatic testDisable();
    startRun(100, 50, 1'b0);
    push(90, 1'b0, 0, "R10 start");
    push(150, 1'b1, 1, "R10 fire");
    startRun(100, 50, 1'b0);
    push(90, 1'b0, 0, "R10 rerun");
    push(100, 1'b1, 1, "R10 restarts armed");
  endtask

  task automatic testCfgHold();
    startRun(100, 50, 1'b0);
    trigLevel   = 16'd300;
    rearmLevel  = 16'd280;
    fallingEdge = 1'b1;
    push(90,  1'b0, 0, "R11 start");
    push(100, 1'b1, 1, "R11 old level used");
    startRun(300, 280, 1'b0);
    push(100, 1'b0, 0, "R11 new level low");
    push(299, 1'b0, 0, "R11 below new level");
    push(300, 1'b1, 2, "R11 new level used");
  endtask

  task automatic testSigned();
    startRun(0, -10, 1'b0);
    push(-1, 1'b0, 0, "R2 negative");
    push(0,  1'b1, 1, "R2 signed crossing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRising();
    testFalling();
    testFirstAbove();
    testInvalid();
    testDisable();
    testCfgHold();
    testSigned();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule